// File: doc/BRIEF.md
# Programmable Multi-Period Refresh Generator

This block drives refresh decisions for a DRAM whose array is refreshed in small blocks rather than whole rows. A block pointer walks through every refresh block, one block per `refresh_tick`. One full walk is a sweep, and the sweep length is the shortest refresh period. Next to this base period the block keeps several longer period classes. Each longer class counts completed sweeps and comes due once every N sweeps, where N is a multiple set after manufacture. This lets leaky blocks get refreshed often while blocks that hold their charge well are refreshed rarely.

The generator presents a registered vector with one bit per period class. The vector says which classes are due in the sweep now in progress. A per-block class table gives every refresh block a class tag. The tag of the block under the pointer selects one bit of the vector, and that bit becomes `refresh_permit`. The surrounding controller refreshes the addressed block only when the permit is high.

The multiples are held in configuration registers that take the place of fuses. The class tags are held in a small register table. Both are written through simple strobed ports.

Top module: `refresh_period_gen`

## Requirements
- R1: `blk_addr` advances by one on each clock edge where `refresh_tick` is 1. It goes from NUM_BLOCKS-1 back to 0. It holds its value on edges without a tick.
- R2: `due_vec[0]` (the base class) is 1 in every sweep.
- R3: For a class k ≥ 1 whose multiple field holds v, the class's sweep counter advances on each wrap edge, which is a tick while `blk_addr` = NUM_BLOCKS-1. When the counter is at or above v, it returns to 0 instead of advancing. `due_vec[k]` is 1 exactly for the sweeps in which the counter is 0, so the class is due once every v+1 sweeps.
- R4: A multiple field of 0 makes its class due in every sweep.
- R5: `due_vec` changes only on a wrap edge and stays constant for the rest of a sweep.
- R6: A configuration load with `cfg_sel` = 0 changes nothing, because class 0 is always the base period.
- R7: A multiple loaded with `cfg_load`/`cfg_sel`/`cfg_mult_m1` is first used at the next wrap edge after the load edge. A load on the same edge as a wrap is first used at the wrap after that.
- R8: A synchronous reset sets `blk_addr` to 0, every sweep counter to 0, every multiple field to 0, and every class tag to 0. It also sets all bits of `due_vec` to 1, so the first sweep refreshes every block.
- R9: `refresh_permit` equals `due_vec[t]`, where t is the class tag stored for `blk_addr`. A tag written with `tag_we` is used from the clock cycle after its write edge.
- R10: If the multiple of a class is lowered below that class's current counter value, the class returns to 0 and is due at the next wrap edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refresh_tick | input | 1 | Advance the block pointer by one block |
| cfg_load | input | 1 | Load strobe for a period multiple |
| cfg_sel | input | CLS_W | Class whose multiple is loaded (0 is ignored) |
| cfg_mult_m1 | input | MULT_W | Multiple minus one (0 means every sweep) |
| tag_we | input | 1 | Write strobe for the class table |
| tag_addr | input | AW | Refresh block whose tag is written |
| tag_class | input | CLS_W | Class tag to store |
| blk_addr | output | AW | Refresh block currently addressed |
| due_vec | output | NUM_CLASSES | Per-class due flags for the current sweep |
| refresh_permit | output | 1 | Addressed block may be refreshed in this sweep |

## Verification
`blk_addr` and `due_vec` are registered results of the edge that samples a tick. A wrap tick therefore shows its new pointer and due vector one clock edge later. `refresh_permit` is a combinational read of that state and of the class table, so it is valid in the same cycle as the pointer. A table write is seen one edge after its strobe, and a multiple write is seen only at the next wrap edge after its strobe. The bench drives every input at a falling edge and lets exactly one rising edge pass. It then steps a behavioural model through the same edge and compares every output at the next falling edge, so each result is sampled in the cycle in which it is due.

// File: rtl/rpg_pkg.sv
`timescale 1ns/1ps
package rpg_pkg;

    // Default geometry of the generator
    localparam int DEF_BLOCKS  = 16;
    localparam int DEF_CLASSES = 4;
    localparam int DEF_MULT_W  = 3;

    // Pointer event raised by the block pointer on each clock
    typedef struct packed {
        logic step;   // pointer moves this edge
        logic wrap;   // pointer completes a sweep this edge
    } sweep_evt_t;

    // Width needed to index n items (at least one bit)
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rpg_addr_ctr.sv
`timescale 1ns/1ps
module rpg_addr_ctr
    import rpg_pkg::*;
#(
    parameter int NUM_BLOCKS = DEF_BLOCKS,
    localparam int AW = idx_width(NUM_BLOCKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [AW-1:0] addr,
    output sweep_evt_t    evt
);

    localparam logic [AW-1:0] LAST = AW'(NUM_BLOCKS - 1);

    always_comb begin
        evt.step = tick;
        evt.wrap = tick && (addr == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (evt.wrap) begin
            addr <= '0;
        end else if (evt.step) begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/rpg_period_ctr.sv
`timescale 1ns/1ps
module rpg_period_ctr
    import rpg_pkg::*;
#(
    parameter int MULT_W = DEF_MULT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MULT_W-1:0] cfg_m1,
    input  sweep_evt_t        evt,
    output logic              due
);

    logic [MULT_W-1:0] mult_q;   // fuse stand-in: multiple minus one
    logic [MULT_W-1:0] sweeps_q; // completed sweeps within the period
    logic              roll;

    // Decoded end of period: true once per programmed period
    assign roll = (sweeps_q >= mult_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_q   <= '0;
            sweeps_q <= '0;
            due      <= 1'b1;
        end else begin
            if (cfg_we) begin
                mult_q <= cfg_m1;
            end
            if (evt.wrap) begin
                if (roll) begin
                    sweeps_q <= '0;
                    due      <= 1'b1;
                end else begin
                    sweeps_q <= sweeps_q + 1'b1;
                    due      <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rpg_class_table.sv
`timescale 1ns/1ps
module rpg_class_table
    import rpg_pkg::*;
#(
    parameter int NUM_BLOCKS  = DEF_BLOCKS,
    parameter int NUM_CLASSES = DEF_CLASSES,
    localparam int AW    = idx_width(NUM_BLOCKS),
    localparam int CLS_W = idx_width(NUM_CLASSES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [CLS_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [CLS_W-1:0] rdata
);

    logic [CLS_W-1:0] tags_q [NUM_BLOCKS];

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                tags_q[b] <= '0;
            end else if (we && (waddr == AW'(b))) begin
                tags_q[b] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (raddr == AW'(b)) begin
                rdata = tags_q[b];
            end
        end
    end

endmodule

// File: rtl/refresh_period_gen.sv
`timescale 1ns/1ps
module refresh_period_gen
    import rpg_pkg::*;
#(
    parameter int NUM_BLOCKS  = DEF_BLOCKS,
    parameter int NUM_CLASSES = DEF_CLASSES,
    parameter int MULT_W      = DEF_MULT_W,
    localparam int AW    = idx_width(NUM_BLOCKS),
    localparam int CLS_W = idx_width(NUM_CLASSES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   refresh_tick,
    input  logic                   cfg_load,
    input  logic [CLS_W-1:0]       cfg_sel,
    input  logic [MULT_W-1:0]      cfg_mult_m1,
    input  logic                   tag_we,
    input  logic [AW-1:0]          tag_addr,
    input  logic [CLS_W-1:0]       tag_class,
    output logic [AW-1:0]          blk_addr,
    output logic [NUM_CLASSES-1:0] due_vec,
    output logic                   refresh_permit
);

    sweep_evt_t       evt;
    logic [CLS_W-1:0] cur_tag;

    rpg_addr_ctr #(.NUM_BLOCKS(NUM_BLOCKS)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .tick (refresh_tick),
        .addr (blk_addr),
        .evt  (evt)
    );

    // Base class: due on every sweep, held in a register like the others
    always_ff @(posedge clk) begin
        if (rst) begin
            due_vec[0] <= 1'b1;
        end else if (evt.wrap) begin
            due_vec[0] <= 1'b1;
        end
    end

    for (genvar k = 1; k < NUM_CLASSES; k++) begin : g_class
        logic we_k;
        assign we_k = cfg_load && (cfg_sel == CLS_W'(k));
        rpg_period_ctr #(.MULT_W(MULT_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .cfg_we (we_k),
            .cfg_m1 (cfg_mult_m1),
            .evt    (evt),
            .due    (due_vec[k])
        );
    end

    rpg_class_table #(.NUM_BLOCKS(NUM_BLOCKS), .NUM_CLASSES(NUM_CLASSES)) u_tags (
        .clk   (clk),
        .rst   (rst),
        .we    (tag_we),
        .waddr (tag_addr),
        .wdata (tag_class),
        .raddr (blk_addr),
        .rdata (cur_tag)
    );

    if ((1 << CLS_W) == NUM_CLASSES) begin : g_full_sel
        assign refresh_permit = due_vec[cur_tag];
    end else begin : g_guard_sel
        // tags beyond the last class fall back to always refresh
        always_comb begin
            refresh_permit = 1'b1;
            for (int k = 0; k < NUM_CLASSES; k++) begin
                if (cur_tag == CLS_W'(k)) begin
                    refresh_permit = due_vec[k];
                end
            end
        end
    end

endmodule

// File: rtl/rpg_chk.sv
`timescale 1ns/1ps
module rpg_chk
    import rpg_pkg::*;
#(
    parameter int NUM_BLOCKS  = DEF_BLOCKS,
    parameter int NUM_CLASSES = DEF_CLASSES,
    localparam int AW = idx_width(NUM_BLOCKS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   refresh_tick,
    input logic [AW-1:0]          blk_addr,
    input logic [NUM_CLASSES-1:0] due_vec,
    input logic                   refresh_permit
);

    localparam logic [AW-1:0] LAST = AW'(NUM_BLOCKS - 1);

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
        (refresh_tick && blk_addr != LAST) |=> (blk_addr == $past(blk_addr) + 1'b1));

    assert_addr_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (refresh_tick && blk_addr == LAST) |=> (blk_addr == '0));

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !refresh_tick |=> $stable(blk_addr));

    assert_due_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(refresh_tick && blk_addr == LAST) |=> $stable(due_vec));

    assert_reset_state_R8: assert property (@(posedge clk)
        $fell(rst) |-> (blk_addr == '0 && (&due_vec)));

    assert_permit_all_R9: assert property (@(posedge clk) disable iff (rst)
        (&due_vec) |-> refresh_permit);

endmodule

bind refresh_period_gen rpg_chk #(
    .NUM_BLOCKS  (NUM_BLOCKS),
    .NUM_CLASSES (NUM_CLASSES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .refresh_tick   (refresh_tick),
    .blk_addr       (blk_addr),
    .due_vec        (due_vec),
    .refresh_permit (refresh_permit)
);

// File: tb/refresh_period_gen_tb.sv
`timescale 1ns/1ps
module refresh_period_gen_tb;

    localparam int NB = 16;
    localparam int K  = 4;
    localparam int MW = 3;
    localparam int AW = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          refresh_tick = 1'b0;
    logic          cfg_load = 1'b0;
    logic [CW-1:0] cfg_sel = '0;
    logic [MW-1:0] cfg_mult_m1 = '0;
    logic          tag_we = 1'b0;
    logic [AW-1:0] tag_addr = '0;
    logic [CW-1:0] tag_class = '0;
    logic [AW-1:0] blk_addr;
    logic [K-1:0]  due_vec;
    logic          refresh_permit;

    refresh_period_gen #(.NUM_BLOCKS(NB), .NUM_CLASSES(K), .MULT_W(MW)) u_dut (
        .clk(clk), .rst(rst), .refresh_tick(refresh_tick),
        .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_mult_m1(cfg_mult_m1),
        .tag_we(tag_we), .tag_addr(tag_addr), .tag_class(tag_class),
        .blk_addr(blk_addr), .due_vec(due_vec), .refresh_permit(refresh_permit)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    int    addr_m;
    int    cnt_m  [K];
    int    mult_m [K];
    bit    due_m  [K];
    int    tag_m  [NB];
    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    string ctx    = "R8";

    task automatic model_reset();
        addr_m = 0;
        for (int k = 0; k < K; k++) begin
            cnt_m[k] = 0; mult_m[k] = 0; due_m[k] = 1'b1;
        end
        for (int b = 0; b < NB; b++) tag_m[b] = 0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, ctx, what, act, exp);
        end
    endtask

    task automatic compare_all(input bit wrapped);
        check("R1", "blk_addr", int'(blk_addr), addr_m);
        check("R2", "due_vec[0]", int'(due_vec[0]), 1);
        for (int k = 1; k < K; k++)
            check(wrapped ? "R3" : "R5", $sformatf("due_vec[%0d]", k), int'(due_vec[k]), int'(due_m[k]));
        check("R9", "refresh_permit", int'(refresh_permit), int'(due_m[tag_m[addr_m]]));
    endtask

    // One clock: drive at falling edge, model the rising edge, compare at next falling edge
    task automatic step(input bit tk, input bit ld, input int sel, input int val,
                        input bit twe, input int ta, input int td);
        bit wrap;
        refresh_tick = tk; cfg_load = ld; cfg_sel = CW'(sel); cfg_mult_m1 = MW'(val);
        tag_we = twe; tag_addr = AW'(ta); tag_class = CW'(td);
        @(posedge clk);
        wrap = tk && (addr_m == NB - 1);
        if (wrap) begin
            for (int k = 1; k < K; k++) begin
                cnt_m[k] = (cnt_m[k] >= mult_m[k]) ? 0 : cnt_m[k] + 1;
                due_m[k] = (cnt_m[k] == 0);
            end
        end
        if (ld && sel != 0) mult_m[sel] = val;
        if (twe) tag_m[ta] = td;
        if (tk) addr_m = (addr_m + 1) % NB;
        @(negedge clk);
        refresh_tick = 1'b0; cfg_load = 1'b0; tag_we = 1'b0;
        compare_all(wrap);
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic tick(); step(1, 0, 0, 0, 0, 0, 0); endtask
    task automatic load(input int sel, input int val); step(0, 1, sel, val, 0, 0, 0); endtask

    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick();
            for (int g = 0; g < gap; g++) idle();
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state, all classes due and pointer at block 0
        ctx = "R8";
        compare_all(1'b0);
        check("R8", "due_vec all ones", int'(&due_vec), 1);

        // R4: every multiple at its reset value 0, every class due each sweep
        ctx = "R4";
        run_ticks(2 * NB + 3, 0);
        check("R4", "due_vec all ones after two sweeps", int'(&due_vec), 1);

        // R7: program multiples mid-sweep; they start at the next wrap
        ctx = "R7";
        load(2, 2);
        load(3, 7);
        load(1, 0);
        run_ticks(NB, 1);

        // R6: a load aimed at class 0 is ignored
        ctx = "R6";
        load(0, 5);
        check("R6", "due_vec[0] after class-0 load", int'(due_vec[0]), 1);

        // R9: spread class tags over the blocks
        ctx = "R9";
        for (int b = 0; b < NB; b++) step(0, 0, 0, 0, 1, b, (b * 3) % K);
        run_ticks(3 * NB, 0);

        // R3: long run with irregular tick spacing
        ctx = "R3";
        for (int s = 0; s < 10; s++) run_ticks(NB, s % 3);

        // R10: lower class 3 multiple below its current count
        ctx = "R10";
        while (cnt_m[3] < 3) run_ticks(NB, 0);
        run_ticks(5, 0);
        load(3, 1);
        while (addr_m != NB - 1) tick();
        tick();
        check("R10", "due_vec[3] after lowered multiple", int'(due_vec[3]), 1);
        run_ticks(3 * NB, 0);

        // R7: load on the very wrap edge takes effect one sweep later
        ctx = "R7";
        while (addr_m != NB - 1) tick();
        step(1, 1, 2, 0, 0, 0, 0);
        run_ticks(4 * NB, 0);

        // R1: pointer holds between ticks
        ctx = "R1";
        for (int i = 0; i < 20; i++) begin
            idle();
            step(1, 0, 0, 0, 0, 0, 0);
            idle();
        end

        // R8: reset in mid-run restores the start state
        ctx = "R8";
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        compare_all(1'b0);
        run_ticks(2 * NB, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule